// File: doc/BRIEF.md
# Vectored Interrupt Priority Nesting Unit

This block holds the vector table and the priority state of a vectored interrupt controller. Sixteen vector slots each carry a control field and a handler address, and one more register holds the default handler address for sources that no slot claims. From the slot controls the block derives one source mask per priority level. It drives the normal interrupt request only when an enabled source outranks the level now in service.

Software enters a handler by reading the vector word. That read returns the handler address and, as a side effect, moves the current level up to the pending slot. The previous level goes onto a per-level history. Software leaves a handler by writing the vector word. The written data is ignored and the saved level comes back, so handlers can preempt each other to any depth across seventeen levels: the sixteen slots plus the unvectored default. Raw and enabled normal-class source vectors come from a separate masking front end.

Top module: `vic_prio_nest`

## Requirements
- R1: After a synchronous reset, every slot address, every slot control and the default address read as zero. The current level is idle (no handler in service), and `irq_out` and `bus_rvalid` are low.
- R2: Slot k's address is at byte offset 0x100+4k and its control at 0x200+4k. Control reads return bits 5:0 zero-extended. The default address is at 0x034 and the vector word at 0x030. A read raises `bus_rvalid` with `bus_rdata` on the clock edge after the cycle in which `bus_rd` is high.
- R3: Control bit 5 enables a slot and bits 4:0 name its source; slot 0 ranks highest. The mask of level i is the OR of the source bits of all enabled slots below i. Level 16 covers every enabled slot, and the idle level covers all sources.
- R4: `irq_out` is the OR of `norm_src` AND the current level's mask, registered one cycle.
- R5: A vector read finds the lowest level i, below the current level, for which `raw_src` AND mask(i+1) is nonzero. It saves the current level in history(i), makes i current, and returns that slot's address.
- R6: When only sources no enabled slot claims are pending, a vector read from idle enters level 16 and returns the default address.
- R7: A vector read from idle with no raw source pending returns the default address and leaves the level idle.
- R8: A vector read that finds nothing outranking the current level leaves the level unchanged and returns the current slot's address.
- R9: A write to the vector word ignores its data and restores the current level from its history entry. At idle it has no effect.
- R10: Two handlers nest. A higher slot preempts a lower one, and two acknowledge writes restore first the lower slot and then idle.
- R11: A slot control write changes the priority masks in time for a vector read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| raw_src | input | 32 | Raw normal-class source levels |
| norm_src | input | 32 | Enabled normal-class source levels |
| irq_out | output | 1 | Normal interrupt request, gated by current level |

## Verification
The current level is internal. A wrong value shows up in two places at the ports: the request is gated wrongly two edges after the fault, and the next vector read returns the wrong handler address one edge after the read. For that reason the bench follows every level change with a vector read or a gating probe. A corrupted history entry stays hidden until the matching acknowledge write. The nesting sequence therefore unwinds both levels and probes the state after each pop.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [11:0] OFS_VEC        = 12'h030;
  localparam logic [11:0] OFS_DEF        = 12'h034;
  localparam logic [11:0] OFS_SLOT_ADDR  = 12'h100;
  localparam logic [11:0] OFS_SLOT_CTRL  = 12'h200;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_SADDR,
    ACC_SCTRL,
    ACC_VEC,
    ACC_DEF
  } acc_e;
endpackage

// File: rtl/vic_mask_build.sv
module vic_mask_build #(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_N     = 32,
  parameter int SEL_W     = 5
) (
  input  logic [NUM_SLOTS*(SEL_W+1)-1:0] ctrl_flat,
  output logic [(NUM_SLOTS+2)*SRC_N-1:0] mask_flat
);
  localparam int CW = SEL_W + 1;

  logic [SRC_N-1:0] cum [NUM_SLOTS+1];

  assign cum[0] = '0;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [CW-1:0]    c;
    logic [SRC_N-1:0] bit_s;
    assign c     = ctrl_flat[s*CW +: CW];
    assign bit_s = c[SEL_W] ? (SRC_N'(1) << c[SEL_W-1:0]) : '0;
    assign cum[s+1] = cum[s] | bit_s;
  end

  for (genvar l = 0; l <= NUM_SLOTS; l++) begin : g_lvl
    assign mask_flat[l*SRC_N +: SRC_N] = cum[l];
  end

  assign mask_flat[(NUM_SLOTS+1)*SRC_N +: SRC_N] = '1;
endmodule

// File: rtl/vic_prio_search.sv
module vic_prio_search #(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_N     = 32,
  parameter int PRIO_W    = 5
) (
  input  logic [SRC_N-1:0]               raw_src,
  input  logic [(NUM_SLOTS+2)*SRC_N-1:0] mask_flat,
  input  logic [PRIO_W-1:0]              cur_prio,
  output logic                           found,
  output logic [PRIO_W-1:0]              found_lvl
);
  localparam int NLVL = NUM_SLOTS + 1;

  logic [NLVL-1:0] hit;

  for (genvar i = 0; i < NLVL; i++) begin : g_hit
    assign hit[i] = (PRIO_W'(i) < cur_prio) &&
                    (|(raw_src & mask_flat[(i+1)*SRC_N +: SRC_N]));
  end

  always_comb begin
    found     = 1'b0;
    found_lvl = '0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found     = 1'b1;
        found_lvl = PRIO_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_prio_nest.sv
module vic_prio_nest #(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_N     = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [SRC_N-1:0]  raw_src,
  input  logic [SRC_N-1:0]  norm_src,
  output logic              irq_out
);
  import vic_pkg::*;

  localparam int SEL_W  = $clog2(SRC_N);
  localparam int CW     = SEL_W + 1;
  localparam int IDX_W  = $clog2(NUM_SLOTS);
  localparam int WIN_LO = 2 + IDX_W;
  localparam int PRIO_W = $clog2(NUM_SLOTS + 2);
  localparam logic [PRIO_W-1:0] LVL_DEF  = PRIO_W'(NUM_SLOTS);
  localparam logic [PRIO_W-1:0] LVL_IDLE = PRIO_W'(NUM_SLOTS + 1);
  localparam logic [ADDR_W-1:0] A_SADDR  = ADDR_W'(OFS_SLOT_ADDR);
  localparam logic [ADDR_W-1:0] A_SCTRL  = ADDR_W'(OFS_SLOT_CTRL);
  localparam logic [ADDR_W-1:0] A_VEC    = ADDR_W'(OFS_VEC);
  localparam logic [ADDR_W-1:0] A_DEF    = ADDR_W'(OFS_DEF);

  logic [DATA_W-1:0] slot_addr [NUM_SLOTS];
  logic [CW-1:0]     slot_ctrl [NUM_SLOTS];
  logic [DATA_W-1:0] def_addr;
  logic [PRIO_W-1:0] cur_prio;
  logic [PRIO_W-1:0] history [NUM_SLOTS+1];

  logic [NUM_SLOTS*CW-1:0]          ctrl_flat;
  logic [(NUM_SLOTS+2)*SRC_N-1:0]   mask_flat;
  logic [SRC_N-1:0]                 cur_mask;
  logic                             found;
  logic [PRIO_W-1:0]                found_lvl;
  logic [PRIO_W-1:0]                next_lvl;
  logic [DATA_W-1:0]                vec_data;
  logic [IDX_W-1:0]                 slot_sel;
  acc_e                             acc;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_flat
    assign ctrl_flat[s*CW +: CW] = slot_ctrl[s];
  end

  vic_mask_build #(
    .NUM_SLOTS(NUM_SLOTS), .SRC_N(SRC_N), .SEL_W(SEL_W)
  ) u_mask (
    .ctrl_flat(ctrl_flat),
    .mask_flat(mask_flat)
  );

  vic_prio_search #(
    .NUM_SLOTS(NUM_SLOTS), .SRC_N(SRC_N), .PRIO_W(PRIO_W)
  ) u_search (
    .raw_src  (raw_src),
    .mask_flat(mask_flat),
    .cur_prio (cur_prio),
    .found    (found),
    .found_lvl(found_lvl)
  );

  assign cur_mask = mask_flat[cur_prio*SRC_N +: SRC_N];
  assign slot_sel = bus_addr[WIN_LO-1:2];
  assign next_lvl = found ? found_lvl : cur_prio;
  assign vec_data = (next_lvl >= LVL_DEF) ? def_addr
                                          : slot_addr[next_lvl[IDX_W-1:0]];

  always_comb begin
    if (bus_addr[ADDR_W-1:WIN_LO] == A_SADDR[ADDR_W-1:WIN_LO])      acc = ACC_SADDR;
    else if (bus_addr[ADDR_W-1:WIN_LO] == A_SCTRL[ADDR_W-1:WIN_LO]) acc = ACC_SCTRL;
    else if (bus_addr == A_VEC)                                     acc = ACC_VEC;
    else if (bus_addr == A_DEF)                                     acc = ACC_DEF;
    else                                                            acc = ACC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        slot_addr[s] <= '0;
        slot_ctrl[s] <= '0;
      end
      for (int l = 0; l <= NUM_SLOTS; l++) history[l] <= LVL_IDLE;
      def_addr   <= '0;
      cur_prio   <= LVL_IDLE;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq_out    <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      irq_out    <= |(norm_src & cur_mask);

      if (bus_rd) begin
        case (acc)
          ACC_SADDR: bus_rdata <= slot_addr[slot_sel];
          ACC_SCTRL: bus_rdata <= DATA_W'(slot_ctrl[slot_sel]);
          ACC_VEC:   bus_rdata <= vec_data;
          ACC_DEF:   bus_rdata <= def_addr;
          default:   bus_rdata <= '0;
        endcase
      end

      if (bus_rd && acc == ACC_VEC) begin
        if (found) begin
          history[found_lvl] <= cur_prio;
          cur_prio           <= found_lvl;
        end
      end else if (bus_wr && acc == ACC_VEC && cur_prio != LVL_IDLE) begin
        cur_prio <= history[cur_prio];
      end

      if (bus_wr) begin
        case (acc)
          ACC_SADDR: slot_addr[slot_sel] <= bus_wdata;
          ACC_SCTRL: slot_ctrl[slot_sel] <= bus_wdata[CW-1:0];
          ACC_DEF:   def_addr            <= bus_wdata;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vic_prio_nest_chk.sv
module vic_prio_nest_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_N     = 32,
  parameter int ADDR_W    = 12,
  parameter int PRIO_W    = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic [SRC_N-1:0]  norm_src,
  input logic              irq_out,
  input logic [PRIO_W-1:0] cur_prio
);
  localparam logic [PRIO_W-1:0] LVL_IDLE = PRIO_W'(NUM_SLOTS + 1);
  logic is_vec;
  assign is_vec = (bus_addr == ADDR_W'(vic_pkg::OFS_VEC));

  AST_RST_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (cur_prio == LVL_IDLE && !irq_out && !bus_rvalid)); // R1
  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R2
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid); // R2
  AST_NO_SRC_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    ($past(norm_src) == '0) |-> !irq_out); // R4
  AST_READ_RAISES: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && is_vec) |=> (cur_prio <= $past(cur_prio))); // R5
  AST_ACK_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && is_vec) |=> (cur_prio >= $past(cur_prio))); // R9
  AST_ACK_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && is_vec && cur_prio == LVL_IDLE) |=> (cur_prio == LVL_IDLE)); // R9
  AST_PRIO_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cur_prio <= LVL_IDLE); // R10
endmodule

bind vic_prio_nest vic_prio_nest_chk #(
  .NUM_SLOTS(NUM_SLOTS), .SRC_N(SRC_N), .ADDR_W(ADDR_W), .PRIO_W(PRIO_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rvalid(bus_rvalid), .norm_src(norm_src), .irq_out(irq_out),
  .cur_prio(cur_prio)
);

// File: tb/vic_prio_nest_tb.sv
`timescale 1ns/1ps
module vic_prio_nest_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_rvalid, irq_out;
  logic [31:0] raw_src = '0, norm_src = '0;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  localparam logic [11:0] A_VEC = 12'h030, A_DEF = 12'h034;
  localparam logic [31:0] S3 = 32'h8, S7 = 32'h80, S9 = 32'h200, S12 = 32'h1000;

  always #2.5 clk = ~clk;

  vic_prio_nest u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .raw_src(raw_src), .norm_src(norm_src), .irq_out(irq_out)
  );

  task automatic result(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) result(1'b0, "R2 unexpected rvalid", 32'h1, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        result(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    repeat (3) @(negedge clk);
    result(irq_out == e, t, 32'(irq_out), 32'(e));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    result(1'b0, "watchdog", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    result(irq_out == 1'b0 && bus_rvalid == 1'b0, "R1 outputs in reset",
           {30'd0, irq_out, bus_rvalid}, 32'h0);
    rst = 1'b0;
    rd(12'h100, 32'h0, "R1 slot0 addr reset");
    rd(12'h204, 32'h0, "R1 slot1 ctrl reset");
    rd(A_DEF,   32'h0, "R1 default reset");

    // slot0: src3, slot1: src7, slot2: src9 disabled; src12 unclaimed
    wr(12'h100, 32'hA000); wr(12'h200, 32'h23);
    wr(12'h104, 32'hB000); wr(12'h204, 32'hFF27);
    wr(12'h108, 32'hC000); wr(12'h208, 32'h09);
    wr(A_DEF,   32'hD000);
    rd(12'h104, 32'hB000, "R2 slot1 addr");
    rd(12'h204, 32'h27,   "R2 slot1 ctrl bits 5:0");
    rd(A_DEF,   32'hD000, "R2 default addr");

    rd(A_VEC, 32'hD000, "R7 idle read no pending");
    norm_src = S7;
    chk_irq(1'b1, "R7 level stays idle, R4 idle passes all");

    raw_src = S7;
    rd(A_VEC, 32'hB000, "R5 enter slot1");
    chk_irq(1'b0, "R4 slot1 masks own source");
    raw_src = S3 | S7; norm_src = S3 | S7;
    chk_irq(1'b1, "R3 slot0 outranks slot1");
    rd(A_VEC, 32'hA000, "R10 preempt to slot0");
    chk_irq(1'b0, "R3 level0 mask empty");
    rd(A_VEC, 32'hA000, "R8 nothing higher at slot0");
    wr(A_VEC, 32'h1234_5678);
    chk_irq(1'b1, "R10 first pop back to slot1");
    raw_src = S7; norm_src = S7;
    rd(A_VEC, 32'hB000, "R10 R8 level is slot1 after pop");
    wr(A_VEC, 32'h0);
    chk_irq(1'b1, "R10 second pop to idle");
    raw_src = '0;
    wr(A_VEC, 32'hFFFF);
    rd(A_VEC, 32'hD000, "R9 ack at idle no effect");
    chk_irq(1'b1, "R9 still idle");

    raw_src = S12; norm_src = S12;
    rd(A_VEC, 32'hD000, "R6 unclaimed source enters default");
    chk_irq(1'b0, "R6 level16 masks unclaimed source");
    wr(A_VEC, 32'h0);
    chk_irq(1'b1, "R9 pop from level16 to idle");

    raw_src = S9; norm_src = '0;
    rd(A_VEC, 32'hD000, "R3 disabled slot ignored");
    wr(A_VEC, 32'h0);
    exp_q.push_back(32'hC000);
    tag_q.push_back("R11 control write used next cycle");
    @(negedge clk); bus_wr = 1'b1; bus_addr = 12'h208; bus_wdata = 32'h29;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = A_VEC;
    @(negedge clk); bus_rd = 1'b0;
    norm_src = S9;
    chk_irq(1'b0, "R4 slot2 masks own source");
    norm_src = S3;
    chk_irq(1'b1, "R3 slot2 level passes slot0 source");
    wr(A_VEC, 32'h0);

    repeat (4) @(negedge clk);
    result(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 32'h0);
    finish_up();
  end
endmodule